// File: doc/BRIEF.md
# Serial Control and Status Port, 16-bit, LSB First

This block is a serial slave port that sits between a host and the control logic of a driver stage. A host lowers the select line, toggles the serial clock and presents data on the serial input. During that frame the port shifts a control word in and a status word out, least significant bit first. The control word goes to a holding register only when the select line returns high after a whole frame. The holding register drives the downstream control logic. The status word is taken from that logic at the moment the frame opens.

The serial output carries status bit 0 as soon as the port is selected, before any clock edge. A host can therefore read that bit with an empty frame, which leaves every register as it was. The output is enabled only while the port is selected, so an external buffer can tri-state it. Bits clocked in beyond one word leave the output again after a delay of one word, which allows several ports to share one chain.

The serial lines are sampled by a faster system clock, brought through synchronizer stages and turned into edge events. All state therefore lives in the system clock domain, with a synchronous active-high reset.

Top module: `serctl_port`

## Requirements
- R1: During reset and after it the holding register reads 0xE000 (bits 15, 14 and 13 set, bits 12..0 clear) and the output enable is low.
- R2: The output enable is low while select is high and goes high after select falls.
- R3: Once select has fallen, the serial output shows bit 0 of the status word, before any clock edge.
- R4: The status word is captured when select falls. On the rising serial clock edge that follows the k-th falling edge, the output moves to status bit k, for k = 1..15. It holds its value between rising edges, and later changes of the status input do not affect the frame.
- R5: The serial input is sampled on falling clock edges. The first bit sampled is bit 0 of the word. After a 16-clock frame, the rise of select loads the word into the holding register.
- R6: The holding register does not change while a frame is in progress. It changes only when select rises.
- R7: A frame of fewer than 16 clocks, including one with no clocks at all, leaves the holding register unchanged.
- R8: A frame is accepted only when its clock count is a nonzero multiple of 16. The holding register then takes the last 16 bits received. Any other count leaves it unchanged.
- R9: After the 16th clock, each rising edge presents on the output the bit that was sampled 16 falling edges earlier.
- R10: Clock and data activity while select is high changes neither the holding register nor the output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| csn_i | input | 1 | Select, active low; its falling edge opens a frame and its rising edge closes it |
| sclk_i | input | 1 | Serial clock; input is sampled on its falling edge and the output advances on its rising edge |
| sdi_i | input | 1 | Serial data in, LSB first |
| sdo_o | output | 1 | Serial data out, LSB first |
| sdo_oe_o | output | 1 | Drive enable for an external tri-state buffer on sdo_o |
| status_i | input | WORD_W | Status word, captured when the frame opens |
| ctrl_o | output | WORD_W | Holding register for the control word |

## Verification
The bench uses the default 16-bit word, two synchronizer stages and the 0xE000 reset value. At that size it can sweep every frame length from 0 to 33 clocks plus a 48-clock chain. That covers the whole accept rule: empty reads, short frames, counts one above and one below a word boundary, and two- and three-word chains. With a 16-bit word it is also practical to walk a single one through every bit position in both directions and to check every output bit of every frame.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  // idle levels of the synchronized serial lines: {sdi, sclk, csn}
  localparam int unsigned LINE_N = 3;
  localparam logic [LINE_N-1:0] LINE_IDLE = 3'b001;
  localparam int unsigned IDX_CSN  = 0;
  localparam int unsigned IDX_SCLK = 1;
  localparam int unsigned IDX_SDI  = 2;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] IDLE  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] q_out
);
  for (genvar b = 0; b < N; b++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= {STAGES{IDLE[b]}};
      else     chain_q <= {chain_q[STAGES-2:0], d_in[b]};
    end
    assign q_out[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/serctl_edge.sv
module serctl_edge #(
  parameter int unsigned N     = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;
  always_ff @(posedge clk) begin
    if (rst) prev_q <= IDLE;
    else     prev_q <= lvl;
  end
  for (genvar b = 0; b < N; b++) begin : g_det
    assign rise[b] = lvl[b] & ~prev_q[b];
    assign fall[b] = ~lvl[b] & prev_q[b];
  end
endmodule

// File: rtl/serctl_shift.sv
module serctl_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              selected,
  input  logic              sclk_fall,
  input  logic              sclk_rise,
  input  logic              sdi,
  input  logic [WORD_W-1:0] status_in,
  output logic              tx_bit,
  output logic              tx_oe,
  output logic [WORD_W-1:0] rx_word,
  output logic              frame_ok
);
  localparam int unsigned CW = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] rx_q, tx_q;
  logic [CW-1:0]     cnt_q;
  logic              full_q, pend_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q   <= '0;
      tx_q   <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      pend_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (cs_fall) begin
      tx_q   <= status_in;
      cnt_q  <= '0;
      full_q <= 1'b0;
      pend_q <= 1'b0;
      oe_q   <= 1'b1;
    end else if (cs_rise) begin
      pend_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (selected) begin
      if (sclk_fall) begin
        rx_q   <= {sdi, rx_q[WORD_W-1:1]};
        pend_q <= 1'b1;
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          full_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (sclk_rise && pend_q) begin
        // newest received bit enters at the top; a word later it leaves at bit 0
        tx_q   <= {rx_q[WORD_W-1], tx_q[WORD_W-1:1]};
        pend_q <= 1'b0;
      end
    end
  end

  assign tx_bit   = tx_q[0];
  assign tx_oe    = oe_q;
  assign rx_word  = rx_q;
  assign frame_ok = cs_rise & full_q & (cnt_q == '0);
endmodule

// File: rtl/serctl_commit.sv
module serctl_commit #(
  parameter int unsigned WORD_W = 16,
  parameter logic [WORD_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= RESET_VAL;
    else if (load) q <= d;
  end
endmodule

// File: rtl/serctl_port.sv
module serctl_port
  import serctl_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] CTRL_RESET = WORD_W'(16'hE000)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic [WORD_W-1:0] status_i,
  output logic [WORD_W-1:0] ctrl_o
);
  logic [LINE_N-1:0] line_s;
  logic [1:0]        ev_rise, ev_fall;
  logic              cs_fall_w, cs_rise_w, sclk_fall_w, sclk_rise_w;
  logic              commit_w;
  logic [WORD_W-1:0] rx_word_w;

  serctl_sync #(.N(LINE_N), .STAGES(SYNC_STAGES), .IDLE(LINE_IDLE)) sync_i (
    .clk(clk), .rst(rst),
    .d_in({sdi_i, sclk_i, csn_i}),
    .q_out(line_s)
  );

  serctl_edge #(.N(2), .IDLE(LINE_IDLE[1:0])) edge_i (
    .clk(clk), .rst(rst),
    .lvl({line_s[IDX_SCLK], line_s[IDX_CSN]}),
    .rise(ev_rise), .fall(ev_fall)
  );

  assign cs_fall_w   = ev_fall[0];
  assign cs_rise_w   = ev_rise[0];
  assign sclk_fall_w = ev_fall[1];
  assign sclk_rise_w = ev_rise[1];

  serctl_shift #(.WORD_W(WORD_W)) shift_i (
    .clk(clk), .rst(rst),
    .cs_fall(cs_fall_w), .cs_rise(cs_rise_w),
    .selected(~line_s[IDX_CSN]),
    .sclk_fall(sclk_fall_w), .sclk_rise(sclk_rise_w),
    .sdi(line_s[IDX_SDI]),
    .status_in(status_i),
    .tx_bit(sdo_o), .tx_oe(sdo_oe_o),
    .rx_word(rx_word_w), .frame_ok(commit_w)
  );

  serctl_commit #(.WORD_W(WORD_W), .RESET_VAL(CTRL_RESET)) commit_i (
    .clk(clk), .rst(rst),
    .load(commit_w), .d(rx_word_w), .q(ctrl_o)
  );
endmodule

// File: rtl/serctl_port_chk.sv
module serctl_port_chk #(
  parameter int unsigned WORD_W = 16,
  parameter logic [WORD_W-1:0] CTRL_RESET = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_fall,
  input logic              cs_rise,
  input logic              sclk_rise,
  input logic              commit,
  input logic              sdo,
  input logic              sdo_oe,
  input logic              status0,
  input logic [WORD_W-1:0] ctrl
);
  // R1
  ctrl_reset_chk: assert property (@(posedge clk) rst |=> ctrl == CTRL_RESET);
  // R2
  oe_on_chk: assert property (@(posedge clk) disable iff (rst) cs_fall |=> sdo_oe);
  // R2
  oe_off_chk: assert property (@(posedge clk) disable iff (rst) cs_rise |=> !sdo_oe);
  // R3
  first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> sdo == $past(status0));
  // R4
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> $past(sclk_rise || cs_fall));
  // R6
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl) |-> $past(commit && cs_rise));
endmodule

bind serctl_port serctl_port_chk #(.WORD_W(WORD_W), .CTRL_RESET(CTRL_RESET)) chk_i (
  .clk(clk), .rst(rst),
  .cs_fall(cs_fall_w), .cs_rise(cs_rise_w), .sclk_rise(sclk_rise_w),
  .commit(commit_w), .sdo(sdo_o), .sdo_oe(sdo_oe_o),
  .status0(status_i[0]), .ctrl(ctrl_o)
);

// File: tb/serctl_port_tb_top.sv
`timescale 1ns/1ps
module serctl_port_tb_top;
  localparam int unsigned W = 16;
  localparam int unsigned HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [W-1:0] status = '0;
  logic [W-1:0] ctrl;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [W-1:0] exp_ctrl;

  always #2 clk = ~clk;

  serctl_port dut_i (
    .clk(clk), .rst(rst), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .status_i(status), .ctrl_o(ctrl)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [W-1:0] st, input logic [47:0] din, input int n);
    status = st;
    csn = 1'b0;
    step(HALF);
    chk("R2 oe after select", {31'b0, sdo_oe}, 1);
    chk("R3 bit0 before clock", {31'b0, sdo}, {31'b0, st[0]});
    status = ~st;  // R4: capture happened at frame start
    for (int i = 0; i < n; i++) begin
      sdi = din[i];
      step(4);
      sclk = 1'b1;
      step(HALF);
      if (i < 16) chk("R4 status order", {31'b0, sdo}, {31'b0, st[i]});
      else        chk("R9 chain pass", {31'b0, sdo}, {31'b0, din[i-16]});
      sclk = 1'b0;
      step(HALF);
    end
    chk("R6 held during frame", {16'b0, ctrl}, {16'b0, exp_ctrl});
    csn = 1'b1;
    step(HALF);
    if (n >= 16 && n % 16 == 0) exp_ctrl = din[n-16 +: 16];
    if (n == 16)     chk("R5 commit", {16'b0, ctrl}, {16'b0, exp_ctrl});
    else if (n < 16) chk("R7 short frame", {16'b0, ctrl}, {16'b0, exp_ctrl});
    else             chk("R8 length rule", {16'b0, ctrl}, {16'b0, exp_ctrl});
    chk("R2 oe off", {31'b0, sdo_oe}, 0);
  endtask

  initial begin
    step(6);
    chk("R1 reset ctrl", {16'b0, ctrl}, 32'hE000);
    chk("R1 reset oe", {31'b0, sdo_oe}, 0);
    rst = 1'b0;
    step(4);
    chk("R1 ctrl after reset", {16'b0, ctrl}, 32'hE000);
    chk("R2 idle oe", {31'b0, sdo_oe}, 0);
    exp_ctrl = 16'hE000;

    // R7: empty read of status bit 0
    run_frame(16'h0001, 48'h0, 0);
    // R5: walking one through each position, both directions
    for (int k = 0; k < 16; k++)
      run_frame(16'h8000 >> k, 48'(16'h0001 << k), 16);
    // R5: arithmetic pattern sweep
    for (int p = 0; p < 12; p++) begin
      logic [15:0] d;
      d = 16'(p * 16'h1357) ^ 16'(p << 9);
      run_frame(~d ^ 16'(p), {32'h0, d}, 16);
    end
    // R7, R8: every frame length 0..33 with a changing payload
    for (int n = 0; n <= 33; n++)
      run_frame(16'(n * 16'h0F1D), {16'(n * 16'h3C5), 16'(n * 16'hA31 + 5), 16'(~(n * 16'h713))}, n);
    // R9, R8: three-word chain
    run_frame(16'h5AA5, 48'h1234_9ABC_DEF0, 48);
    // R10: clocking while deselected
    for (int i = 0; i < 20; i++) begin
      sdi = i[0];
      step(4); sclk = 1'b1; step(HALF); sclk = 1'b0; step(HALF);
      chk("R10 oe stays low", {31'b0, sdo_oe}, 0);
    end
    chk("R10 ctrl unchanged", {16'b0, ctrl}, {16'b0, exp_ctrl});
    run_frame(16'hC3A0, 48'h0000_0000_7E81, 16);

    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule